// File: doc/BRIEF.md
# Serial Flash Full-Erase Sequencer

This block is a host-side SPI master that wipes an entire serial flash with one request. When `start_i` is pulsed, it first sends the write-enable command in a chip-select frame of its own. It then reads the status register once to confirm that the write-enable latch was set. Next it sends the chip-erase opcode in a frame of its own. Finally it holds chip-select low after a status-read opcode and samples the repeating status bytes until the busy flag drops.

The serial clock runs in SPI mode 0: SCK idles low, the flash samples data on the rising edge, and data moves MSB first. Each SCK half-period lasts `CLK_DIV` system clocks. Between two frames, chip-select stays high for at least `CS_GAP` system clocks. A status stream that still shows busy after `POLL_LIMIT` bytes ends the run with an error. The user side sees a one-cycle `done_o` pulse when the erase succeeds and a one-cycle `err_o` pulse when it fails.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset and while idle, `cs_n_o` is 1, `sck_o` is 0, and `done_o` and `err_o` are 0.
- R2: Bytes are sent MSB first in SPI mode 0. SCK is low whenever chip-select is high. Each SCK high phase lasts `CLK_DIV` system clocks, so an 8-bit frame holds SCK high for 8*`CLK_DIV` clocks.
- R3: A run issues its frames in this order:
  - opcode 0x06 alone (8 bits);
  - opcode 0x05 followed by one status byte;
  - `ERASE_OP` (0xC7 by default, 0x60 also valid) alone;
  - opcode 0x05 followed by the polled status bytes.
- R4: If bit 1 (write-enable latch) of the first status byte is 0, the block pulses `err_o`, raises chip-select and sends no erase frame.
- R5: During polling, chip-select stays low and no further opcode is sent. The first status byte with bit 0 (busy) equal to 0 ends the frame, and `done_o` pulses.
- R6: If `POLL_LIMIT` consecutive status bytes all show busy, the block pulses `err_o` and raises chip-select after exactly `POLL_LIMIT` status bytes.
- R7: Chip-select stays high for at least `CS_GAP` system clocks between any two frames.
- R8: `done_o` and `err_o` are single-cycle pulses, never high together, and exactly one of them fires per run.
- R9: `start_i` is ignored while a run is in progress, so a pulse during a run adds no frames and no second completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a full erase (taken only when idle) |
| done_o | output | 1 | One-cycle pulse: erase finished |
| err_o | output | 1 | One-cycle pulse: latch not set or poll timeout |
| cs_n_o | output | 1 | Flash chip-select, active low |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
The bench contains a behavioural flash model. The model logs each frame's opcode and length and streams live status bytes while chip-select is held low. It also refuses write-enable on demand and can hold busy for any number of status bytes. The corner cases covered are:
- **Immediate idle:** busy reads 0 on the first polled byte. A design that re-issues the opcode or reads one byte too many gives the wrong poll-frame length.
- **Refused write-enable:** a design that ignores the latch check sends a third, erase frame.
- **Busy never clears:** an off-by-one timeout leaves the last frame one byte short or long, and a design without the timeout hangs.
- **Start during a run:** a design that accepts the pulse produces extra frames or a second `done_o`.
- **Gap timing:** short chip-select gaps or the wrong SCK high time show up in the measured gap and high-phase counts.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN,
    ST_CHK_OP,
    ST_CHK_RD,
    ST_ERASE,
    ST_POLL_OP,
    ST_POLL_RD,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  localparam int DW = $clog2(CLK_DIV + 1);

  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    tx_sr;
  logic          active;
  logic          tick;

  assign tick   = (div_cnt == DW'(CLK_DIV - 1));
  assign mosi_o = tx_sr[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sr   <= '0;
      rx_o    <= '0;
      active  <= 1'b0;
      sck_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !active) begin
        active  <= 1'b1;
        tx_sr   <= tx_i;
        sck_o   <= 1'b0;
        bit_cnt <= '0;
        div_cnt <= '0;
      end else if (active) begin
        if (tick) begin
          div_cnt <= '0;
          if (!sck_o) begin
            sck_o <= 1'b1;
            rx_o  <= {rx_o[6:0], miso_i};  // sample on rising edge
          end else begin
            sck_o <= 1'b0;
            if (bit_cnt == 3'd7) begin
              active <= 1'b0;
              done_o <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              tx_sr   <= {tx_sr[6:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + DW'(1);
        end
      end
    end
  end

  p_sck_only_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> active);
  p_mosi_stable_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
endmodule

// File: rtl/cs_gap_timer.sv
module cs_gap_timer #(
  parameter int CS_GAP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  output logic gap_ok_o
);
  localparam int CW = $clog2(CS_GAP + 1);

  logic [CW-1:0] cnt;

  assign gap_ok_o = (cnt >= CW'(CS_GAP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt <= '0;
    else if (!cs_n_i)    cnt <= '0;
    else if (!gap_ok_o)  cnt <= cnt + CW'(1);
  end

  p_gap_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_i |=> !gap_ok_o);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int         CLK_DIV    = 2,
  parameter int         CS_GAP     = 4,
  parameter int         POLL_LIMIT = 8,
  parameter logic [7:0] ERASE_OP   = 8'hC7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o,
  output logic err_o,
  output logic cs_n_o,
  output logic sck_o,
  output logic mosi_o,
  input  logic miso_i
);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  seq_state_e    state_q;
  logic          go_q;
  logic [7:0]    tx_q;
  logic [7:0]    rx;
  logic          xfer_done;
  logic          gap_ok;
  logic [PW-1:0] poll_cnt;
  logic          unused_rx;

  assign unused_rx = ^rx[7:2];

  spi_byte_xfer #(.CLK_DIV(CLK_DIV)) u_xfer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_q),
    .tx_i   (tx_q),
    .miso_i (miso_i),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .rx_o   (rx),
    .done_o (xfer_done)
  );

  cs_gap_timer #(.CS_GAP(CS_GAP)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_i   (cs_n_o),
    .gap_ok_o (gap_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cs_n_o   <= 1'b1;
      go_q     <= 1'b0;
      tx_q     <= '0;
      poll_cnt <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_WREN;
        ST_WREN: begin
          if (cs_n_o) begin
            if (gap_ok) begin cs_n_o <= 1'b0; go_q <= 1'b1; tx_q <= OP_WR_EN; end
          end else if (xfer_done) begin
            cs_n_o  <= 1'b1;
            state_q <= ST_CHK_OP;
          end
        end
        ST_CHK_OP: begin
          if (cs_n_o) begin
            if (gap_ok) begin cs_n_o <= 1'b0; go_q <= 1'b1; tx_q <= OP_STATUS; end
          end else if (xfer_done) begin
            go_q    <= 1'b1;
            tx_q    <= 8'h00;
            state_q <= ST_CHK_RD;
          end
        end
        ST_CHK_RD: begin
          if (xfer_done) begin
            cs_n_o <= 1'b1;
            if (rx[BIT_WEL]) state_q <= ST_ERASE;
            else begin err_o <= 1'b1; state_q <= ST_TAIL; end
          end
        end
        ST_ERASE: begin
          if (cs_n_o) begin
            if (gap_ok) begin cs_n_o <= 1'b0; go_q <= 1'b1; tx_q <= ERASE_OP; end
          end else if (xfer_done) begin
            cs_n_o  <= 1'b1;  // erase begins on this rising edge
            state_q <= ST_POLL_OP;
          end
        end
        ST_POLL_OP: begin
          if (cs_n_o) begin
            if (gap_ok) begin cs_n_o <= 1'b0; go_q <= 1'b1; tx_q <= OP_STATUS; end
          end else if (xfer_done) begin
            go_q     <= 1'b1;
            tx_q     <= 8'h00;
            poll_cnt <= '0;
            state_q  <= ST_POLL_RD;
          end
        end
        ST_POLL_RD: begin
          if (xfer_done) begin
            if (!rx[BIT_BUSY]) begin
              cs_n_o  <= 1'b1;
              done_o  <= 1'b1;
              state_q <= ST_TAIL;
            end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
              cs_n_o  <= 1'b1;
              err_o   <= 1'b1;
              state_q <= ST_TAIL;
            end else begin
              poll_cnt <= poll_cnt + PW'(1);
              go_q     <= 1'b1;  // keep streaming, no new opcode
            end
          end
        end
        ST_TAIL: if (gap_ok) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_idle_cs_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (cs_n_o && !sck_o));
  p_sck_low_deselected_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sck_o);
  p_erase_needs_wel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERASE && $past(state_q) == ST_CHK_RD) |-> $past(rx[BIT_WEL]));
  p_cs_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> $past(gap_ok));
  p_done_err_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_TAIL) |=> (state_q != ST_IDLE));
endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
  localparam int CLK_DIV    = 2;
  localparam int CS_GAP     = 4;
  localparam int POLL_LIMIT = 8;
  localparam logic [7:0] ERASE_OP = 8'hC7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done_o, err_o, cs_n, sck, mosi;
  logic miso = 1'b0;

  always #10 clk = ~clk;

  flash_erase_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT),
                    .ERASE_OP(ERASE_OP)) u_flash_erase_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done_o), .err_o(err_o),
    .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi), .miso_i(miso));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  // flash model state
  int  fr_cnt = 0, bits = 0, busy_init = 0, busy_left = 0;
  bit  refuse = 0, wel = 0;
  logic [7:0] sh = 0, snap = 0;
  logic [7:0] op_log [0:15];
  int  len_log [0:15];
  int  sck_bad = 0, ragged = 0;
  int  first_hi = 0, hi_run = 0;
  int  done_cnt = 0, err_cnt = 0, done_hi = 0, done_w = 0;
  int  gap_run = 0, gap_min = 1000;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge cs_n) begin bits = 0; hi_run = 0; end
  always @(posedge cs_n) begin
    if (bits > 0 && fr_cnt < 16) begin
      len_log[fr_cnt] = bits / 8;
      if (bits % 8 != 0) ragged++;
      if (bits == 8 && op_log[fr_cnt] == 8'h06 && !refuse) wel = 1;
      if (bits == 8 && op_log[fr_cnt] == ERASE_OP && wel) begin
        busy_left = busy_init; wel = 0;
      end
      if (fr_cnt == 0) first_hi = hi_run;
      fr_cnt++;
    end
  end
  always @(posedge sck) begin
    if (cs_n) sck_bad++;
    sh = {sh[6:0], mosi};
    bits++;
    if (bits == 8 && fr_cnt < 16) op_log[fr_cnt] = sh;
  end
  always @(negedge sck) begin
    if (bits >= 8) begin
      if (bits % 8 == 0) begin
        if (bits > 8 && busy_left > 0) busy_left--;
        snap = {6'b0, wel, busy_left != 0};
      end
      miso = snap[7 - ((bits - 8) % 8)];
    end else miso = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (!cs_n && sck) hi_run++;
    if (done_o) done_cnt++;
    if (err_o) err_cnt++;
    if (done_o || err_o) done_w++; else begin
      if (done_w > done_hi) done_hi = done_w;
      done_w = 0;
    end
    if (cs_n) gap_run++;
    else begin
      if (gap_run > 0 && fr_cnt > 0 && gap_run < gap_min) gap_min = gap_run;
      gap_run = 0;
    end
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run(input bit refuse_i, input int busy_i, input bit poke);
    int guard = 0;
    refuse = refuse_i; busy_init = busy_i; wel = 0;
    fr_cnt = 0; done_cnt = 0; err_cnt = 0; done_hi = 0; gap_min = 1000;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!(done_o || err_o) && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (poke && fr_cnt == 2 && guard % 7 == 0) start = 1'b1; else start = 1'b0;
    end
    start = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cs_n == 1 && sck == 0, "R1 cs/sck idle", {cs_n, sck}, 2);
    chk(done_o == 0 && err_o == 0, "R1 flags idle", {done_o, err_o}, 0);
  endtask

  task automatic t_normal;
    run(0, 3, 0);
    chk(fr_cnt == 4, "R3 frame count", fr_cnt, 4);
    chk(op_log[0] == 8'h06 && len_log[0] == 1, "R3 wren frame", op_log[0], 6);
    chk(op_log[1] == 8'h05 && len_log[1] == 2, "R3 check frame", len_log[1], 2);
    chk(op_log[2] == ERASE_OP && len_log[2] == 1, "R3 erase frame", op_log[2], ERASE_OP);
    chk(op_log[3] == 8'h05, "R3 poll opcode", op_log[3], 5);
    chk(len_log[3] == 1 + 4, "R5 poll stream length", len_log[3], 5);
    chk(done_cnt == 1 && err_cnt == 0, "R8 one done", done_cnt, 1);
    chk(done_hi == 1, "R8 pulse width", done_hi, 1);
    chk(gap_min >= CS_GAP, "R7 cs gap", gap_min, CS_GAP);
    chk(first_hi == 8 * CLK_DIV, "R2 sck high time", first_hi, 8 * CLK_DIV);
    chk(sck_bad == 0 && ragged == 0, "R2 framing", sck_bad + ragged, 0);
    chk(cs_n == 1, "R5 cs released", cs_n, 1);
  endtask

  task automatic t_quick;
    run(0, 0, 0);
    chk(len_log[3] == 2, "R5 immediate idle", len_log[3], 2);
    chk(done_cnt == 1 && err_cnt == 0, "R5 done", done_cnt, 1);
  endtask

  task automatic t_wel_fail;
    run(1, 3, 0);
    chk(fr_cnt == 2, "R4 no erase frame", fr_cnt, 2);
    chk(err_cnt == 1 && done_cnt == 0, "R4 err pulse", err_cnt, 1);
    chk(cs_n == 1, "R4 cs high", cs_n, 1);
  endtask

  task automatic t_timeout;
    run(0, 50, 0);
    chk(err_cnt == 1 && done_cnt == 0, "R6 err on timeout", err_cnt, 1);
    chk(len_log[3] == 1 + POLL_LIMIT, "R6 poll bytes", len_log[3], 1 + POLL_LIMIT);
    chk(cs_n == 1 && fr_cnt == 4, "R6 cs released", fr_cnt, 4);
    chk(done_hi == 1, "R8 err width", done_hi, 1);
  endtask

  task automatic t_start_ignored;
    run(0, 2, 1);
    chk(fr_cnt == 4, "R9 no extra frames", fr_cnt, 4);
    chk(done_cnt == 1, "R9 single done", done_cnt, 1);
    repeat (300) @(negedge clk);
    chk(fr_cnt == 4 && cs_n == 1, "R9 no restart", fr_cnt, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_normal;
    t_quick;
    t_wel_fail;
    t_timeout;
    t_start_ignored;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule